// File: doc/BRIEF.md
# DDR3 Mode Register 3 Calibration-Read Controller

This block sits on the device side of a DDR3-style memory command interface. It decodes mode-register-set commands aimed at mode register 3 and holds that register's calibration-read state: one enable bit and a two-bit location field. While the enable bit is set, column reads are served from a fixed training pattern source instead of the memory array. The pattern is an eight-beat burst whose beats alternate between all-zeros and all-ones on every data bit, which a controller uses for read-capture alignment.

The block also polices the command stream. An MR3 write is accepted only when every bank is idle and all reserved bits are zero; otherwise it reports an error and leaves the register as it was. While calibration-read mode is active, every command other than a read, a read with auto-precharge, an MR3 write that clears the enable, a NOP or a deselect is flagged as illegal. Power-down or self-refresh entry, signalled by a clock-enable falling strobe, is flagged the same way. Reset still works in this mode and returns the register to normal operation.

Top module: `ddr3_mpr_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every output is 0 and the register holds enable 0, location 00.
- R2: An MRS (cs_n, ras_n, cas_n, we_n all 0) with ba = 3'b011, all banks idle and reserved bits zero loads addr[2] as the enable and addr[1:0] as the location, visible on mpr_en_o and mpr_loc_o one cycle later.
- R3: An MRS whose ba[1:0] is not 2'b11 leaves the MR3 state unchanged and raises no flag while calibration-read mode is off.
- R4: An accepted MR3 write with addr[2] = 0 ignores addr[1:0] and sets the location to 00.
- R5: An MR3 write with ba[2] = 1 or any of addr[13:3] nonzero pulses mrs_rsvd_err_o one cycle later and does not change the register.
- R6: An MR3 write while any bank_idle bit is 0 pulses mrs_busy_err_o one cycle later and does not change the register.
- R7: A read (cs_n=0, ras_n=1, cas_n=0, we_n=1) issued while the enable is set pulses rd_redirect_o one cycle later, with rd_autopre_o equal to addr[10]; with the enable clear a read produces no redirect and no burst.
- R8: While the enable is set, activate (011), write (100), precharge (010), refresh (001), ZQ calibration (110), any MRS other than an MR3 write with addr[2] = 0, and a cke_fall pulse each pulse illegal_cmd_o one cycle later without changing the register; NOP (111) and deselect (cs_n=1) are legal, and nothing is flagged while the enable is clear.
- R9: Reset asserted while calibration-read mode is active returns the block to the R1 state.
- R10: For location 00, a redirected read produces eight beats with mpr_dq_valid_o high, starting in the same cycle as rd_redirect_o; beat k drives every data bit to 1 when k is odd and 0 when k is even; a new read during a burst restarts it at beat 0.
- R11: For a reserved location (01, 10 or 11) a redirected read produces eight valid beats of all-zero data with mpr_rsvd_hit_o high on each of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address; selects the mode register on MRS |
| addr | input | 14 | Address bus; MR3 payload on MRS, auto-precharge on bit 10 for reads |
| bank_idle | input | 8 | One bit per bank, 1 when precharged and precharge time met |
| cke_fall | input | 1 | Strobe marking power-down or self-refresh entry |
| mpr_en_o | output | 1 | Calibration-read mode enable |
| mpr_loc_o | output | 2 | Selected pattern location |
| illegal_cmd_o | output | 1 | Pulse: command illegal in calibration-read mode |
| mrs_rsvd_err_o | output | 1 | Pulse: MR3 write with reserved bits set |
| mrs_busy_err_o | output | 1 | Pulse: MR3 write with a bank not idle |
| rd_redirect_o | output | 1 | Pulse: read served from the pattern source |
| rd_autopre_o | output | 1 | Auto-precharge flag of the redirected read |
| mpr_dq_valid_o | output | 1 | Pattern burst beat valid |
| mpr_dq_o | output | 8 | Pattern burst data |
| mpr_rsvd_hit_o | output | 1 | Current burst comes from a reserved location |

## Verification
On every cycle the embedded assertions check that a rejected MR3 write leaves the register untouched, that the location reads 00 whenever the enable is clear, that redirects and illegal-command flags appear only when the enable was set a cycle earlier, and that pattern data only ever sits at all-zeros or all-ones and toggles between beats. Only the bench's scenarios can show the exact beat order and burst length, the restart of a burst by a second read, the auto-precharge value, which command codes count as illegal, that NOP and deselect are tolerated, and that reset clears an active calibration-read mode.

// File: rtl/ddr3_mpr_pkg.sv
// Package: shared command encoding and register type for the MR3
// calibration-read controller. Assumes the usual DDR3 RAS/CAS/WE order.
package ddr3_mpr_pkg;

    // {ras_n, cas_n, we_n} with cs_n low
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_ZQ  = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef struct packed {
        logic       en;
        logic [1:0] loc;
    } mr3_t;

    localparam logic [1:0] LOC_PATTERN = 2'b00;
    localparam logic [1:0] MR3_SEL     = 2'b11;

endpackage

// File: rtl/mpr_cmd_decode.sv
// Module: mpr_cmd_decode
// Classifies the command pins into MRS, read, NOP/deselect and all other
// commands. Purely combinational; assumes pins are already sampled.
module mpr_cmd_decode
    import ddr3_mpr_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic is_mrs,
    output logic is_rd,
    output logic is_other
);

    cmd_e code;

    // Purpose: map pins to a command class.
    always_comb begin
        code     = cmd_e'({ras_n, cas_n, we_n});
        is_mrs   = 1'b0;
        is_rd    = 1'b0;
        is_other = 1'b0;
        if (!cs_n) begin
            unique case (code)
                CMD_MRS: is_mrs   = 1'b1;
                CMD_RD:  is_rd    = 1'b1;
                CMD_NOP: ;
                default: is_other = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/mpr_mode_reg.sv
// Module: mpr_mode_reg
// Holds the MR3 enable and location. Accepts an MR3 write only when all
// banks are idle and reserved bits are zero; while enabled, only a write
// that clears the enable is considered. Reports rejected writes one cycle
// later. Assumes ADDR_W >= 4 so that reserved bits exist.
module mpr_mode_reg
    import ddr3_mpr_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_mrs,
    input  logic [2:0]           ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_idle,
    output mr3_t                 state_o,
    output logic                 mrs_bad_o,
    output logic                 rsvd_err_o,
    output logic                 busy_err_o
);

    localparam int EN_BIT   = 2;
    localparam int RSVD_LSB = EN_BIT + 1;

    mr3_t state_q;
    logic to_mr3;
    logic consider;
    logic rsvd_set;
    logic all_idle;

    // Purpose: classify the current MRS against MR3 rules.
    always_comb begin
        to_mr3    = is_mrs && (ba[1:0] == MR3_SEL);
        consider  = to_mr3 && (!state_q.en || !addr[EN_BIT]);
        rsvd_set  = ba[2] || (addr[ADDR_W-1:RSVD_LSB] != '0);
        all_idle  = &bank_idle;
        mrs_bad_o = state_q.en && is_mrs && !(to_mr3 && !addr[EN_BIT]);
    end

    // Purpose: update the register and the rejection flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= '0;
            rsvd_err_o <= 1'b0;
            busy_err_o <= 1'b0;
        end else begin
            rsvd_err_o <= consider && rsvd_set;
            busy_err_o <= consider && !all_idle;
            if (consider && !rsvd_set && all_idle) begin
                state_q.en  <= addr[EN_BIT];
                state_q.loc <= addr[EN_BIT] ? addr[1:0] : LOC_PATTERN;
            end
        end
    end

    assign state_o = state_q;

    p_loc_clear_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.en |-> (state_q.loc == LOC_PATTERN));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (consider && !all_idle) |=> $stable(state_q));

    p_rsvd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (consider && rsvd_set) |=> $stable(state_q));

endmodule

// File: rtl/mpr_pattern_gen.sv
// Module: mpr_pattern_gen
// Produces the calibration burst: BURST_LEN beats starting the cycle after
// start_i, alternating all-zero / all-one words, or all zeros with a flag
// for a reserved location. A new start restarts the burst at beat 0.
module mpr_pattern_gen #(
    parameter int DQ_W      = 8,
    parameter int BURST_LEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            rsvd_loc_i,
    output logic            valid_o,
    output logic [DQ_W-1:0] dq_o,
    output logic            rsvd_hit_o
);

    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

    logic             active_q;
    logic             rsvd_q;
    logic [CNT_W-1:0] beat_q;
    logic             last;

    assign last = (beat_q == LAST_BEAT);

    // Purpose: track burst activity and beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rsvd_q   <= 1'b0;
            beat_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            rsvd_q   <= rsvd_loc_i;
            beat_q   <= '0;
        end else if (active_q) begin
            if (last) begin
                active_q <= 1'b0;
                beat_q   <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Purpose: form the beat data from the beat parity.
    always_comb begin
        valid_o    = active_q;
        rsvd_hit_o = active_q && rsvd_q;
        dq_o       = (active_q && !rsvd_q) ? {DQ_W{beat_q[0]}} : '0;
    end

    p_beat_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !rsvd_q && !last && !start_i) |=> (dq_o != $past(dq_o)));

endmodule

// File: rtl/ddr3_mpr_ctrl.sv
// Module: ddr3_mpr_ctrl (top)
// Decodes commands, keeps MR3 calibration-read state, redirects reads to
// the pattern generator while enabled and flags commands that are illegal
// in that mode. All flags are registered and appear one cycle after the
// command. Assumes one command per clock and cke_fall as a one-cycle strobe.
module ddr3_mpr_ctrl
    import ddr3_mpr_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_BANKS = 8,
    parameter int DQ_W      = 8,
    parameter int BURST_LEN = 8,
    parameter int AP_BIT    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [2:0]           ba,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 cke_fall,
    output logic                 mpr_en_o,
    output logic [1:0]           mpr_loc_o,
    output logic                 illegal_cmd_o,
    output logic                 mrs_rsvd_err_o,
    output logic                 mrs_busy_err_o,
    output logic                 rd_redirect_o,
    output logic                 rd_autopre_o,
    output logic                 mpr_dq_valid_o,
    output logic [DQ_W-1:0]      mpr_dq_o,
    output logic                 mpr_rsvd_hit_o
);

    logic is_mrs, is_rd, is_other;
    logic mrs_bad;
    logic redirect;
    logic illegal;
    mr3_t mr3;

    mpr_cmd_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .is_mrs   (is_mrs),
        .is_rd    (is_rd),
        .is_other (is_other)
    );

    mpr_mode_reg #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_mrs     (is_mrs),
        .ba         (ba),
        .addr       (addr),
        .bank_idle  (bank_idle),
        .state_o    (mr3),
        .mrs_bad_o  (mrs_bad),
        .rsvd_err_o (mrs_rsvd_err_o),
        .busy_err_o (mrs_busy_err_o)
    );

    // Purpose: decide redirect and illegal status from the current mode.
    always_comb begin
        redirect = mr3.en && is_rd;
        illegal  = mr3.en && (is_other || mrs_bad || cke_fall);
    end

    // Purpose: register the per-command flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_cmd_o <= 1'b0;
            rd_redirect_o <= 1'b0;
            rd_autopre_o  <= 1'b0;
        end else begin
            illegal_cmd_o <= illegal;
            rd_redirect_o <= redirect;
            rd_autopre_o  <= redirect && addr[AP_BIT];
        end
    end

    mpr_pattern_gen #(
        .DQ_W      (DQ_W),
        .BURST_LEN (BURST_LEN)
    ) u_pat (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (redirect),
        .rsvd_loc_i (mr3.loc != LOC_PATTERN),
        .valid_o    (mpr_dq_valid_o),
        .dq_o       (mpr_dq_o),
        .rsvd_hit_o (mpr_rsvd_hit_o)
    );

    assign mpr_en_o  = mr3.en;
    assign mpr_loc_o = mr3.loc;

    p_redirect_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_redirect_o |-> $past(mpr_en_o));

    p_illegal_needs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd_o |-> $past(mpr_en_o));

    p_dq_levels_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mpr_dq_valid_o && !mpr_rsvd_hit_o) |-> (mpr_dq_o == '0 || mpr_dq_o == '1));

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mpr_rsvd_hit_o |-> (mpr_dq_valid_o && mpr_dq_o == '0));

endmodule

// File: tb/ddr3_mpr_ctrl_tb_top.sv
// Scoreboard bench: the driver applies one command per cycle at the falling
// edge, advances a requirement-level model and queues the expected outputs;
// the monitor compares them 1 ns after the next rising edge.
module ddr3_mpr_ctrl_tb_top;

    typedef struct packed {
        logic [17:0] vec;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]  ba = '0;
    logic [13:0] addr = '0;
    logic [7:0]  bank_idle = 8'hFF;
    logic        cke_fall = 1'b0;
    logic        mpr_en_o, illegal_cmd_o, mrs_rsvd_err_o, mrs_busy_err_o;
    logic        rd_redirect_o, rd_autopre_o, mpr_dq_valid_o, mpr_rsvd_hit_o;
    logic [1:0]  mpr_loc_o;
    logic [7:0]  mpr_dq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    exp_t sb_q[$];

    // model state
    logic       m_en = 0;
    logic [1:0] m_loc = 0;
    logic       b_act = 0, b_rsvd = 0;
    int         b_beat = 0;

    always #2 clk = ~clk;

    ddr3_mpr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .bank_idle(bank_idle),
        .cke_fall(cke_fall), .mpr_en_o(mpr_en_o), .mpr_loc_o(mpr_loc_o),
        .illegal_cmd_o(illegal_cmd_o), .mrs_rsvd_err_o(mrs_rsvd_err_o),
        .mrs_busy_err_o(mrs_busy_err_o), .rd_redirect_o(rd_redirect_o),
        .rd_autopre_o(rd_autopre_o), .mpr_dq_valid_o(mpr_dq_valid_o),
        .mpr_dq_o(mpr_dq_o), .mpr_rsvd_hit_o(mpr_rsvd_hit_o)
    );

    // Apply one cycle of stimulus and queue the outputs expected after the edge.
    task automatic step(input logic [2:0] cmd, input logic c_n, input logic [2:0] b,
                        input logic [13:0] a, input logic [7:0] idle,
                        input logic ckf, input logic rn, input int req);
        logic is_mrs, is_rd, other, mr3w, cons, rsv, bz;
        logic e_ill, e_rs, e_bz, e_rd, e_ap;
        logic [7:0] e_dq;
        exp_t item;
        @(negedge clk);
        {ras_n, cas_n, we_n} = cmd;
        cs_n = c_n; ba = b; addr = a; bank_idle = idle; cke_fall = ckf; rst_n = rn;
        is_mrs = !c_n && cmd == 3'b000;
        is_rd  = !c_n && cmd == 3'b101;
        other  = !c_n && !is_mrs && !is_rd && cmd != 3'b111;
        {e_ill, e_rs, e_bz, e_rd, e_ap} = '0;
        if (!rn) begin
            m_en = 0; m_loc = 0; b_act = 0; b_rsvd = 0; b_beat = 0;
        end else begin
            mr3w = is_mrs && b[1:0] == 2'b11;
            if (m_en) e_ill = ckf || other || (is_mrs && !(mr3w && !a[2]));
            if (m_en && is_rd) begin
                e_rd = 1; e_ap = a[10];
                b_act = 1; b_beat = 0; b_rsvd = (m_loc != 2'b00);
            end else if (b_act) begin
                if (b_beat == 7) begin b_act = 0; b_beat = 0; end
                else b_beat++;
            end
            cons = mr3w && (!m_en || !a[2]);
            if (cons) begin
                rsv = b[2] || a[13:3] != 0;
                bz  = idle != 8'hFF;
                e_rs = rsv; e_bz = bz;
                if (!rsv && !bz) begin
                    m_en = a[2]; m_loc = a[2] ? a[1:0] : 2'b00;
                end
            end
        end
        e_dq = (b_act && !b_rsvd) ? {8{b_beat[0]}} : 8'h00;
        item.vec = {e_ill, e_rs, e_bz, m_en, m_loc, e_rd, e_ap, b_act,
                    b_act && b_rsvd, e_dq};
        item.req = 8'(req);
        sb_q.push_back(item);
    endtask

    task automatic idle_cyc(input int n, input int req);
        for (int i = 0; i < n; i++) step(3'b111, 1'b1, 3'b0, 14'h0, 8'hFF, 0, 1, req);
    endtask

    task automatic mrs(input logic [2:0] b, input logic [13:0] a,
                       input logic [7:0] idle, input int req);
        step(3'b000, 1'b0, b, a, idle, 0, 1, req);
    endtask

    // Monitor: pop and compare one expected item per cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [17:0] act;
                e = sb_q.pop_front();
                act = {illegal_cmd_o, mrs_rsvd_err_o, mrs_busy_err_o, mpr_en_o,
                       mpr_loc_o, rd_redirect_o, rd_autopre_o, mpr_dq_valid_o,
                       mpr_rsvd_hit_o, mpr_dq_o};
                checks++;
                if (act !== e.vec) begin
                    errors++;
                    $display("FAIL R%0d at %0t: actual %b expected %b", e.req, $time, act, e.vec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(3'b111, 1'b1, 3'b0, 14'h0, 8'hFF, 0, 0, 1);
        step(3'b111, 1'b1, 3'b0, 14'h0, 8'hFF, 0, 0, 1);
        idle_cyc(1, 1);
        // R3: MRS to MR1 / MR2 in normal mode leaves MR3 alone
        mrs(3'b001, 14'h0004, 8'hFF, 3);
        mrs(3'b010, 14'h0007, 8'hFF, 3);
        // R8: nothing flagged in normal mode
        step(3'b011, 1'b0, 3'b0, 14'h0, 8'hFF, 1, 1, 8);
        // R7: read in normal mode is not redirected
        step(3'b101, 1'b0, 3'b0, 14'h0400, 8'hFF, 0, 1, 7);
        idle_cyc(2, 7);
        // R2: enable with pattern location
        mrs(3'b011, 14'h0004, 8'hFF, 2);
        // R10: pattern burst
        step(3'b101, 1'b0, 3'b0, 14'h0000, 8'hFF, 0, 1, 10);
        idle_cyc(9, 10);
        // R7: read with auto-precharge, then R10 restart mid-burst
        step(3'b101, 1'b0, 3'b0, 14'h0400, 8'hFF, 0, 1, 7);
        idle_cyc(3, 10);
        step(3'b101, 1'b0, 3'b0, 14'h0000, 8'hFF, 0, 1, 10);
        idle_cyc(9, 10);
        // R8: illegal commands in MPR mode
        step(3'b011, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        step(3'b100, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        step(3'b010, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        step(3'b001, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        step(3'b110, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        step(3'b111, 1'b1, 3'b0, 14'h0, 8'hFF, 1, 1, 8);
        mrs(3'b001, 14'h0000, 8'hFF, 8);
        mrs(3'b011, 14'h0006, 8'hFF, 8);
        // R8: NOP and deselect are legal
        step(3'b111, 1'b0, 3'b0, 14'h0, 8'hFF, 0, 1, 8);
        idle_cyc(1, 8);
        // R4: disable with A1:A0 = 11 ignored
        mrs(3'b011, 14'h0003, 8'hFF, 4);
        idle_cyc(1, 4);
        // R6: bank busy blocks enable
        mrs(3'b011, 14'h0004, 8'hEF, 6);
        idle_cyc(1, 6);
        // R5: reserved address bit and BA2
        mrs(3'b011, 14'h0024, 8'hFF, 5);
        mrs(3'b111, 14'h0004, 8'hFF, 5);
        mrs(3'b011, 14'h2004, 8'hFF, 5);
        idle_cyc(1, 5);
        // R11: reserved location read
        mrs(3'b011, 14'h0006, 8'hFF, 11);
        step(3'b101, 1'b0, 3'b0, 14'h0000, 8'hFF, 0, 1, 11);
        idle_cyc(9, 11);
        // R9: reset during MPR mode
        step(3'b101, 1'b0, 3'b0, 14'h0000, 8'hFF, 0, 1, 9);
        step(3'b111, 1'b1, 3'b0, 14'h0, 8'hFF, 0, 0, 9);
        idle_cyc(2, 9);
        step(3'b101, 1'b0, 3'b0, 14'h0000, 8'hFF, 0, 1, 9);
        idle_cyc(3, 9);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule